// File: doc/BRIEF.md
# Multi-channel DAC update controller

This block sits between a host register bus and a small group of serial DACs. It drives up to four output channels and a pair of reference DACs, one positive and one negative. A 16-bit host write to a channel's setting register, or to the shared reference register, queues a 16-bit word for that DAC. One shared shifter sends each word MSB-first, with its own chip-select per DAC and a serial clock divided down from the system clock.

The host sees a status word that is always valid. It has a busy flag per channel, a reference-busy flag and a flag that reports queued work. A host can write a value and then poll until the matching flag drops. The host controls the block with commands written to one control address. The commands switch each channel's enable line, choose how channel data is coded, and throw away queued words.

Each DAC holds one waiting word. A write to a DAC that is still shifting is held and sent later. It is never lost. A second write to the same DAC before its word leaves replaces the waiting value.

Top module: `dac_update_ctrl`

## Requirements
- R1: After reset, `status` is 0, `ch_en` is 0, every chip-select is high and `dac_sclk` is low.
- R2: A write to even byte address 0x38 + 2*ch (ch < NUM_CH) sends 16 bits MSB-first while `dac_cs_n[ch]` is low. This takes 16 rising edges of `dac_sclk`. Each half period lasts CLK_DIV clocks. `dac_sdo` changes only while `dac_sclk` is low, and `dac_sclk` is low whenever no chip-select is low.
- R3: Status bit 4+ch is set in the cycle after a write to channel ch. It stays set until that channel has no word waiting and its chip-select has returned high.
- R4: A write to address 0x2C starts a reference transfer. Bit 8 picks the DAC: 1 drives `ref_cs_n[1]` (positive) and 0 drives `ref_cs_n[0]` (negative). The word sent is {7'b0, bit 8, bits 7:0}, and bits 15:9 are ignored. Status bit 1 is set while either reference has a word waiting or in flight.
- R5: A write to a DAC that is busy is held and sent after the current transfer. A later write to the same DAC before it starts replaces the waiting value.
- R6: When several words wait, the lowest index goes first. Channels 0..NUM_CH-1 come first, then the negative reference, then the positive one.
- R7: Status bit 0 is set exactly while at least one word is waiting behind a transfer.
- R8: Control write 0x0004 (address 0x20, bits 7:4 zero, bit 2 set) throws away every waiting word. It does not affect the word being shifted, and it does not change the data format.
- R9: Control write with bits 7:4 zero and bit 2 clear sets the format from bit 1. With bit 1 = 1 (signed), later channel writes are sent with bit 15 inverted. With bit 1 = 0, the value goes out unchanged. Reference words are never converted.
- R10: Control write with bits 7:4 = ch+2 sets `ch_en[ch]` to bit 0. Other values in bits 7:4 leave `ch_en` unchanged.
- R11: Writes to any other address, or to an odd address, have no effect. Status bits 2 and 3 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 8 | Host byte address |
| wr_data | input | 16 | Host write data |
| status | output | 16 | Status word: queued, reference busy, channel busy bits |
| ch_en | output | NUM_CH | Per-channel enable lines |
| dac_sclk | output | 1 | Shared serial clock |
| dac_sdo | output | 1 | Shared serial data, MSB first |
| dac_cs_n | output | NUM_CH | Channel DAC chip-selects, active low |
| ref_cs_n | output | 2 | Reference chip-selects: bit 1 positive, bit 0 negative |

## Verification
The bench decodes every serial frame and checks it against expected results from a scoreboard. The stimulus covers four cases:
- **A single isolated channel write.** This confirms framing and bit order on their own.
- **Bursts to several DACs while one is shifting.** These separate the correct priority order from plain arrival order.
- **Repeated writes to one busy channel.** These show that the latest waiting value wins and that the in-flight word is left alone.
- **Format and flush commands mixed with writes.** The signed and unsigned words show whether the inversion touches channel data only. Flushing a queue that holds waiting words shows discarded words apart from the word in flight.

Writes to stray addresses, and unused control codes, are checked for silence on the serial lines and no change in status or enables.

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl #(
  parameter int NUM_CH  = 4,
  parameter int CLK_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [15:0]       wr_data,
  output logic [15:0]       status,
  output logic [NUM_CH-1:0] ch_en,
  output logic              dac_sclk,
  output logic              dac_sdo,
  output logic [NUM_CH-1:0] dac_cs_n,
  output logic [1:0]        ref_cs_n
);
  localparam int NCS = NUM_CH + 2;
  localparam int IW  = $clog2(NCS);
  localparam int DW  = $clog2(CLK_DIV + 1);
  localparam logic [7:0] A_CTRL = 8'h20;
  localparam logic [7:0] A_REF  = 8'h2C;
  localparam logic [7:0] A_SET  = 8'h38;
  localparam logic [7:0] A_END  = 8'(A_SET + 2 * NUM_CH);

  logic [NCS-1:0] pend_vld;
  logic [15:0]    pend_dat [NCS];
  logic           active;
  logic [IW-1:0]  act_idx;
  logic [15:0]    shreg;
  logic [4:0]     phase;
  logic [DW-1:0]  div_cnt;
  logic           fmt_signed;
  logic [NCS-1:0] busy;
  logic [NCS-1:0] cs_vec;

  wire is_set = wr_en && !wr_addr[0] && wr_addr >= A_SET && wr_addr < A_END;
  wire is_ref = wr_en && wr_addr == A_REF;
  wire is_ctl = wr_en && wr_addr == A_CTRL;
  wire [7:0]    set_off = wr_addr - A_SET;
  wire [IW-1:0] set_ch  = set_off[IW:1];
  wire [IW-1:0] ref_idx = wr_data[8] ? IW'(NUM_CH + 1) : IW'(NUM_CH);
  wire [3:0]    nib     = wr_data[7:4];
  wire          tick    = div_cnt == DW'(CLK_DIV - 1);

  logic          sel_vld;
  logic [IW-1:0] sel_idx;
  always_comb begin
    sel_vld = 1'b0;
    sel_idx = '0;
    for (int i = NCS - 1; i >= 0; i--)
      if (pend_vld[i]) begin
        sel_vld = 1'b1;
        sel_idx = IW'(i);
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld   <= '0;
      for (int i = 0; i < NCS; i++) pend_dat[i] <= '0;
      active     <= 1'b0;
      act_idx    <= '0;
      shreg      <= '0;
      phase      <= '0;
      div_cnt    <= '0;
      fmt_signed <= 1'b0;
      ch_en      <= '0;
    end else begin
      if (!active && sel_vld) begin
        active            <= 1'b1;
        act_idx           <= sel_idx;
        shreg             <= pend_dat[sel_idx];
        pend_vld[sel_idx] <= 1'b0;
        div_cnt           <= '0;
        phase             <= '0;
      end else if (active) begin
        if (tick) begin
          div_cnt <= '0;
          phase   <= phase + 5'd1;
          if (phase[0]) shreg <= {shreg[14:0], 1'b0};
          if (phase == 5'd31) active <= 1'b0;
        end else begin
          div_cnt <= div_cnt + DW'(1);
        end
      end
      if (is_set) begin
        pend_vld[set_ch] <= 1'b1;
        pend_dat[set_ch] <= fmt_signed ? {~wr_data[15], wr_data[14:0]} : wr_data;
      end
      if (is_ref) begin
        pend_vld[ref_idx] <= 1'b1;
        pend_dat[ref_idx] <= {7'b0, wr_data[8:0]};
      end
      if (is_ctl) begin
        if (nib == 4'd0) begin
          if (wr_data[2]) pend_vld <= '0;
          else            fmt_signed <= wr_data[1];
        end
        for (int i = 0; i < NUM_CH; i++)
          if (nib == 4'(i + 2)) ch_en[i] <= wr_data[0];
      end
    end
  end

  for (genvar g = 0; g < NCS; g++) begin : g_busy
    assign cs_vec[g] = active && act_idx == IW'(g);
    assign busy[g]   = pend_vld[g] | cs_vec[g];
  end

  always_comb begin
    status    = '0;
    status[0] = |pend_vld;
    status[1] = busy[NUM_CH] | busy[NUM_CH+1];
    for (int i = 0; i < NUM_CH; i++) status[4+i] = busy[i];
  end

  assign dac_cs_n = ~cs_vec[NUM_CH-1:0];
  assign ref_cs_n = ~cs_vec[NCS-1:NUM_CH];
  assign dac_sclk = active & phase[0];
  assign dac_sdo  = active & shreg[15];

  assert_one_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~{ref_cs_n, dac_cs_n}));
  assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (&{ref_cs_n, dac_cs_n}) |-> !dac_sclk);
  assert_sdo_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_sclk && $past(dac_sclk)) |-> $stable(dac_sdo));
  assert_ref_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |=> status[1]);
  assert_ref_cs_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_cs_n != 2'b11) |-> status[1]);
  assert_queued_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |-> (status[1] || (|status[NUM_CH+3:4])));
  assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ctl && wr_data == 16'h0004) |=> !status[0]);
  assert_zero_bits_R11: assert property (@(posedge clk) disable iff (!rst_n)
    status[3:2] == 2'b00);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    assert_busy_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (is_set && set_ch == IW'(g)) |=> status[4+g]);
    assert_cs_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_cs_n[g] |-> status[4+g]);
  end
endmodule

// File: tb/sim_dac_update_ctrl.sv
module sim_dac_update_ctrl;
  localparam int NCH = 4;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0] wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] status;
  logic [NCH-1:0] ch_en, dac_cs_n;
  logic [1:0] ref_cs_n;
  logic dac_sclk, dac_sdo;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dac_update_ctrl #(.NUM_CH(NCH), .CLK_DIV(2)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .status(status), .ch_en(ch_en), .dac_sclk(dac_sclk), .dac_sdo(dac_sdo),
    .dac_cs_n(dac_cs_n), .ref_cs_n(ref_cs_n));

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [19:0] expq[$];
  string tagq[$];
  task automatic expect_word(int idx, logic [15:0] w, string tag);
    expq.push_back({4'(idx), w});
    tagq.push_back(tag);
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (status == 16'h0) break;
    end
    @(negedge clk);
  endtask

  bit inxfer = 0, psclk = 0;
  int cap_idx = 0, nbits = 0;
  logic [15:0] sh = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      logic [5:0] cs;
      cs = {ref_cs_n, dac_cs_n};
      if (!inxfer && cs != 6'h3f) begin
        inxfer = 1; sh = 0; nbits = 0;
        for (int i = 0; i < 6; i++) if (!cs[i]) cap_idx = i;
      end
      if (inxfer && dac_sclk && !psclk) begin
        sh = {sh[14:0], dac_sdo};
        nbits++;
      end
      if (inxfer && cs == 6'h3f) begin
        inxfer = 0;
        chk(nbits == 16, "R2 bit count", nbits, 16);
        if (expq.size() == 0) begin
          chk(0, "R11 unexpected transfer", {cap_idx[3:0], sh}, 0);
        end else begin
          logic [19:0] e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          chk({4'(cap_idx), sh} == e, t, {4'(cap_idx), sh}, e);
        end
      end
      psclk = dac_sclk;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(status == 0, "R1 status", status, 0);
    chk(ch_en == 0, "R1 ch_en", ch_en, 0);
    chk({ref_cs_n, dac_cs_n} == 6'h3f, "R1 selects", {ref_cs_n, dac_cs_n}, 6'h3f);
    chk(dac_sclk == 0, "R1 sclk", dac_sclk, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 / R3: isolated channel write
    expect_word(2, 16'hA5C3, "R2 channel frame");
    wr(8'h3C, 16'hA5C3);
    chk(status[6] == 1, "R3 busy rises", status[6], 1);
    repeat (20) @(negedge clk);
    chk(status[6] == 1, "R3 busy held", status[6], 1);
    wait_idle();
    chk(status == 0, "R3 busy clears", status, 0);

    // R4: reference writes
    expect_word(5, 16'h01AB, "R4 positive ref");
    wr(8'h2C, 16'h01AB);
    chk(status[1] == 1, "R4 ref busy", status[1], 1);
    wait_idle();
    expect_word(4, 16'h0055, "R4 negative ref");
    wr(8'h2C, 16'hFE55);
    wait_idle();
    chk(status == 0, "R4 ref busy clears", status, 0);

    // R6 / R7: burst while busy
    expect_word(3, 16'h1111, "R6 first");
    expect_word(0, 16'h3333, "R6 ch0");
    expect_word(2, 16'h2222, "R6 ch2");
    expect_word(4, 16'h0044, "R6 neg ref");
    expect_word(5, 16'h0177, "R6 pos ref");
    wr(8'h3E, 16'h1111);
    wr(8'h3C, 16'h2222);
    chk(status[0] == 1, "R7 queued flag", status[0], 1);
    wr(8'h38, 16'h3333);
    wr(8'h2C, 16'h0177);
    wr(8'h2C, 16'h0044);
    wait_idle();
    chk(status[0] == 0, "R7 queued clears", status[0], 0);

    // R5: latest waiting value wins
    expect_word(1, 16'hAAAA, "R5 in flight");
    expect_word(1, 16'hCCCC, "R5 latest");
    wr(8'h3A, 16'hAAAA);
    wr(8'h3A, 16'hBBBB);
    wr(8'h3A, 16'hCCCC);
    wait_idle();

    // R8: flush
    expect_word(0, 16'h0F0F, "R8 in flight kept");
    wr(8'h38, 16'h0F0F);
    wr(8'h3A, 16'h1234);
    wr(8'h3C, 16'h5678);
    chk(status[0] == 1, "R7 queued before flush", status[0], 1);
    wr(8'h20, 16'h0004);
    chk(status[0] == 0, "R8 queued cleared", status[0], 0);
    chk(status[6:5] == 2'b00, "R8 waiting busy cleared", status[6:5], 0);
    chk(status[4] == 1, "R8 active busy kept", status[4], 1);
    wait_idle();

    // R9: data format
    wr(8'h20, 16'h0002);
    wr(8'h20, 16'h0004);
    expect_word(1, 16'h9234, "R9 signed");
    wr(8'h3A, 16'h1234);
    wait_idle();
    expect_word(4, 16'h00F0, "R9 ref unconverted");
    wr(8'h2C, 16'h00F0);
    wait_idle();
    wr(8'h20, 16'h0000);
    expect_word(1, 16'h1234, "R9 unsigned");
    wr(8'h3A, 16'h1234);
    wait_idle();

    // R10: enables
    wr(8'h20, 16'h0021);
    chk(ch_en == 4'b0001, "R10 enable ch0", ch_en, 4'b0001);
    wr(8'h20, 16'h0051);
    chk(ch_en == 4'b1001, "R10 enable ch3", ch_en, 4'b1001);
    wr(8'h20, 16'h0061);
    chk(ch_en == 4'b1001, "R10 other code ignored", ch_en, 4'b1001);
    wr(8'h20, 16'h0020);
    chk(ch_en == 4'b1000, "R10 disable ch0", ch_en, 4'b1000);
    wr(8'h20, 16'h0041);
    chk(ch_en == 4'b1100, "R10 enable ch2", ch_en, 4'b1100);

    // R11: stray addresses
    wr(8'h40, 16'h1111);
    chk(status == 0, "R11 addr 0x40", status, 0);
    wr(8'h39, 16'h2222);
    chk(status == 0, "R11 odd addr", status, 0);
    wr(8'h10, 16'h0021);
    chk(status == 0, "R11 addr 0x10", status, 0);
    repeat (100) @(negedge clk);
    chk(ch_en == 4'b1100, "R11 enables unchanged", ch_en, 4'b1100);
    chk(expq.size() == 0, "R2 all frames seen", expq.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule